// File: doc/BRIEF.md
# I2S Slave Serial Audio Transmitter

This block turns parallel stereo samples into a serial audio stream for an external master. The master supplies the bit clock (SCK) and the word-select clock (LRCK). The block oversamples both with its own system clock. It changes SDOUT just after each falling SCK edge, so the master can sample it on the next rising edge. A half-frame with LRCK low carries the left sample, and a half-frame with LRCK high carries the right sample.

Two frame formats are supported. In the standard I2S format the MSB of a half-frame is sampled on the second rising SCK edge after LRCK toggles. In the aligned format it is sampled on the first such edge. The sample width is set to 8, 16 or 24 bits. The output is always MSB first and starts at the head of the half-frame. The master decides how many SCK periods a half-frame lasts. Any periods after the LSB carry zeros. If the half-frame is too short, the low-order bits are dropped.

Samples arrive as a left/right pair through a valid/ready port backed by one holding register. `s_ready` is high only while that register is empty. A pair is taken on a clock edge where `s_valid` and `s_ready` are both high. The producer must hold `s_valid` and the data steady until that happens. The stored pair moves to the serializer at the start of the next left half-frame, and the register then empties. If the register is empty at that point, the whole frame is sent as zeros.

Top module: `i2s_slave_tx`

## Requirements
- R1: While `rst_n` is low, `sdout` is low and `s_ready` is high, because the holding register is empty.
- R2: `s_ready` is high exactly when the holding register is empty. A pair is accepted when `s_valid` and `s_ready` are both high at a clock edge. `s_ready` then stays low, and the stored pair stays unchanged, until the pair is consumed at the next left half-frame start.
- R3: A half-frame with LRCK low carries `s_left`, and a half-frame with LRCK high carries `s_right`, of the same accepted pair.
- R4: With `cfg_aligned` = 1, the sample MSB is on `sdout` at the first rising SCK edge after an LRCK transition.
- R5: With `cfg_aligned` = 0 (I2S format), the sample MSB is on `sdout` at the second rising SCK edge after an LRCK transition. The bit at the first rising edge still belongs to the previous half-frame.
- R6: `cfg_width` code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 24 bits. The sample is the W low bits of `s_left`/`s_right`, sent MSB (bit W-1) first. Higher bits are ignored.
- R7: When a half-frame has more SCK periods than W, every bit after the LSB is 0.
- R8: When a half-frame has fewer SCK periods than W, only the leading MSBs are sent and the low-order bits are dropped.
- R9: When a half-frame has exactly W SCK periods, it carries bit W-1 down to bit 0.
- R10: If no pair is held when a left half-frame starts, both half-frames of that frame are all zeros.
- R11: `sdout` changes only in the cycle after a synchronized falling SCK edge. It is stable while SCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples SCK and LRCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Sample width code (0: 8, 1: 16, 2/3: 24 bits) |
| cfg_aligned | input | 1 | 1: aligned format, 0: I2S one-bit-delay format |
| s_valid | input | 1 | Sample pair on `s_left`/`s_right` is valid |
| s_ready | output | 1 | Holding register is empty and can take a pair |
| s_left | input | DW | Left sample, right-justified in the field |
| s_right | input | DW | Right sample, right-justified in the field |
| sck | input | 1 | Bit clock from the external master |
| lrck | input | 1 | Word select from the master (low = left) |
| sdout | output | 1 | Serial data out, updated after falling SCK |

## Verification
The assertions assume the following about the inputs:
- `cfg_width` and `cfg_aligned` change only during reset.
- LRCK changes only together with a falling SCK edge.
- Each SCK level lasts longer than the synchronizer delay plus one clock.
- A pair offered on `s_valid` is held until it is accepted.

The bench stays within these limits. It holds each SCK level for five system clocks and moves LRCK at the same instant SCK falls. It changes the configuration only while reset is asserted, and offers pairs only between frames, while the serial clock is idle.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SAMPLE_MAX = 24;

  typedef enum logic [1:0] {
    WCODE_8   = 2'd0,
    WCODE_16  = 2'd1,
    WCODE_24  = 2'd2,
    WCODE_24X = 2'd3
  } wcode_t;

  function automatic logic [5:0] width_bits(input logic [1:0] code);
    case (wcode_t'(code))
      WCODE_8:  return 6'd8;
      WCODE_16: return 6'd16;
      default:  return 6'd24;
    endcase
  endfunction
endpackage

// File: rtl/i2s_tx_sync.sv
module i2s_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic lr_in,
  output logic sck_fall,
  output logic lr_sync
);
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] lr_pipe;
  logic              sck_last;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_pipe[g] <= 1'b1;
          lr_pipe[g]  <= 1'b1;
        end else begin
          sck_pipe[g] <= sck_in;
          lr_pipe[g]  <= lr_in;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_pipe[g] <= 1'b1;
          lr_pipe[g]  <= 1'b1;
        end else begin
          sck_pipe[g] <= sck_pipe[g-1];
          lr_pipe[g]  <= lr_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_last <= 1'b1;
    else        sck_last <= sck_pipe[STAGES-1];
  end

  assign sck_fall = sck_last & ~sck_pipe[STAGES-1];
  assign lr_sync  = lr_pipe[STAGES-1];

  // R11
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |=> !sck_fall);
endmodule

// File: rtl/i2s_tx_hold.sv
module i2s_tx_hold #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] hold_l,
  output logic [DW-1:0] hold_r
);
  logic accept;

  assign s_ready = ~full;
  assign accept  = s_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
    end else if (accept) begin
      full   <= 1'b1;
      hold_l <= s_left;
      hold_r <= s_right;
    end else if (take) begin
      full   <= 1'b0;
    end
  end

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !take |=> full && $stable(hold_l) && $stable(hold_r));

  // R2
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(s_valid));
endmodule

// File: rtl/i2s_tx_frame.sv
module i2s_tx_frame #(
  parameter int DW    = 24,
  parameter int POS_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_fall,
  input  logic          lr_sync,
  input  logic          cfg_aligned,
  input  logic [5:0]    wbits,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_l,
  input  logic [DW-1:0] hold_r,
  output logic          take,
  output logic          sdout
);
  localparam int IDX_W = $clog2(DW);

  logic             lr_dly, eff_prev, eff, start, left_start;
  logic [POS_W-1:0] pos, pos_n;
  logic [DW-1:0]    act_l, act_r, word;
  logic [IDX_W-1:0] bit_idx;
  logic             in_range, bit_n;

  assign eff        = cfg_aligned ? lr_sync : lr_dly;
  assign start      = eff ^ eff_prev;
  assign left_start = sck_fall & start & ~eff;
  assign take       = left_start;

  always_comb begin
    if (start)     pos_n = '0;
    else if (&pos) pos_n = pos;
    else           pos_n = pos + 1'b1;

    if (left_start) word = hold_full ? hold_l : '0;
    else            word = eff ? act_r : act_l;

    in_range = 32'(pos_n) < 32'(wbits);
    bit_idx  = IDX_W'(32'(wbits) - 32'd1 - 32'(pos_n));
    bit_n    = in_range & word[bit_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_dly   <= 1'b1;
      eff_prev <= 1'b1;
      pos      <= '0;
      act_l    <= '0;
      act_r    <= '0;
      sdout    <= 1'b0;
    end else if (sck_fall) begin
      lr_dly   <= lr_sync;
      eff_prev <= eff;
      pos      <= pos_n;
      sdout    <= bit_n;
      if (left_start) begin
        act_l <= hold_full ? hold_l : '0;
        act_r <= hold_full ? hold_r : '0;
      end
    end
  end

  // R7
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall && !start && (32'(pos) + 1 >= 32'(wbits)) |=> !sdout);

  // R10
  empty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_start && !hold_full |=> act_l == '0 && act_r == '0);
endmodule

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx
  import i2s_tx_pkg::*;
#(
  parameter int DW          = SAMPLE_MAX,
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_aligned,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  input  logic          sck,
  input  logic          lrck,
  output logic          sdout
);
  logic          sck_fall, lr_sync, take, hold_full;
  logic [DW-1:0] hold_l, hold_r;
  logic [5:0]    wbits;

  assign wbits = width_bits(cfg_width);

  i2s_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck), .lr_in(lrck),
    .sck_fall(sck_fall), .lr_sync(lr_sync)
  );

  i2s_tx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .take(take), .full(hold_full),
    .hold_l(hold_l), .hold_r(hold_r)
  );

  i2s_tx_frame #(.DW(DW), .POS_W(POS_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .lr_sync(lr_sync),
    .cfg_aligned(cfg_aligned), .wbits(wbits), .hold_full(hold_full),
    .hold_l(hold_l), .hold_r(hold_r), .take(take), .sdout(sdout)
  );

  // R11
  sdout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(sck_fall));

  logic rst_seen;
  initial rst_seen = 1'b0;
  always @(posedge clk) rst_seen <= 1'b1;

  // R1
  always @(negedge clk) begin
    if (!rst_n && rst_seen) begin
      rst_idle_chk: assert (!sdout && s_ready);
    end
  end
endmodule

// File: tb/i2s_slave_tx_test.sv
module i2s_slave_tx_test;
  localparam int DW   = 24;
  localparam int HALF = 5;

  typedef struct {
    logic [DW-1:0] l;
    logic [DW-1:0] r;
    int            w;
    int            h;
    bit            al;
    bit            none;
  } item_t;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [1:0]    cfg_width = 2'd0;
  logic          cfg_aligned = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_left = '0, s_right = '0;
  logic          sck = 1'b1, lrck = 1'b1;
  logic          sdout;

  int    checks = 0, fails = 0;
  int    hlen = 16;
  item_t exp_q[$];

  always #4 clk = ~clk;

  i2s_slave_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_aligned(cfg_aligned),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .sck(sck), .lrck(lrck), .sdout(sdout)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int wsel(input logic [1:0] code);
    return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 24;
  endfunction

  function automatic logic [63:0] expect_word(input logic [DW-1:0] s, input int w,
                                              input int h);
    logic [63:0] v = '0;
    for (int k = 0; k < h; k++) v = {v[62:0], (k < w) ? s[w-1-k] : 1'b0};
    return v;
  endfunction

  // Monitor: acts as the master's receiver and scoreboard
  logic        mon_lrp = 1'b1, mon_effp = 1'b1, seen_left = 1'b0;
  logic        rise_seen = 1'b0, rise_val = 1'b0;
  logic [63:0] cap_l = '0, cap_r = '0;

  task automatic compare_frame();
    item_t it;
    string sz, fm;
    if (exp_q.size() == 0) begin
      check(1'b0, "R3 unexpected frame", cap_l, 64'd0);
      return;
    end
    it = exp_q.pop_front();
    fm = it.al ? "R4" : "R5";
    sz = it.none ? "R10" : (it.h > it.w) ? "R7" : (it.h < it.w) ? "R8" : "R9";
    check(cap_l == expect_word(it.l, it.w, it.h),
          $sformatf("R3/R6 %s %s left", fm, sz), cap_l, expect_word(it.l, it.w, it.h));
    check(cap_r == expect_word(it.r, it.w, it.h),
          $sformatf("R3/R6 %s %s right", fm, sz), cap_r, expect_word(it.r, it.w, it.h));
  endtask

  always @(posedge sck) begin
    logic eff;
    if (rst_n) begin
      eff = cfg_aligned ? lrck : mon_lrp;
      if (eff != mon_effp) begin
        if (!eff && seen_left) compare_frame();
        if (!eff) begin seen_left = 1'b1; cap_l = '0; end
        else cap_r = '0;
      end
      if (eff) cap_r = {cap_r[62:0], sdout};
      else     cap_l = {cap_l[62:0], sdout};
      mon_effp  = eff;
      mon_lrp   = lrck;
      rise_val  = sdout;
      rise_seen = 1'b1;
    end
  end

  // R11: output held while SCK is high
  always @(negedge sck) begin
    if (rst_n && rise_seen) check(sdout == rise_val, "R11 sdout moved during SCK high",
                                  64'(sdout), 64'(rise_val));
  end

  // Driver
  task automatic push_pair(input logic [DW-1:0] l, input logic [DW-1:0] r);
    item_t it;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    @(negedge clk);
    s_valid = 1'b0;
    it = '{l: l, r: r, w: wsel(cfg_width), h: hlen, al: cfg_aligned, none: 1'b0};
    exp_q.push_back(it);
    check(!s_ready, "R2 ready low while pair held", 64'(s_ready), 64'd0);
  endtask

  task automatic push_none();
    item_t it;
    it = '{l: '0, r: '0, w: wsel(cfg_width), h: hlen, al: cfg_aligned, none: 1'b1};
    exp_q.push_back(it);
  endtask

  task automatic run_frame();
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < hlen; b++) begin
        @(negedge clk);
        sck = 1'b0; lrck = ch[0];
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    check(s_ready, "R2 ready high after pair consumed", 64'(s_ready), 64'd1);
  endtask

  task automatic start_phase(input bit al, input logic [1:0] code, input int h);
    rst_n = 1'b0; s_valid = 1'b0; sck = 1'b1; lrck = 1'b1;
    cfg_aligned = al; cfg_width = code; hlen = h;
    exp_q.delete();
    mon_lrp = 1'b1; mon_effp = 1'b1; seen_left = 1'b0; rise_seen = 1'b0;
    repeat (3) @(negedge clk);
    check(sdout == 1'b0, "R1 sdout low in reset", 64'(sdout), 64'd0);
    check(s_ready == 1'b1, "R1 ready high in reset", 64'(s_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_phase();
    push_none();
    run_frame();
    check(exp_q.size() == 1, "R3 scoreboard drained", 64'(exp_q.size()), 64'd1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R4 R9: aligned, 16-bit, half-frame equals width; R10 gap frame
    start_phase(1'b1, 2'd1, 16);
    push_pair(24'h00A5C3, 24'h003C96); run_frame();
    push_pair(24'h007FFF, 24'h008001); run_frame();
    push_none(); run_frame();
    push_pair(24'h001234, 24'h00FEDC); run_frame();
    end_phase();
    // R5: I2S format, 16-bit
    start_phase(1'b0, 2'd1, 16);
    push_pair(24'h00BEEF, 24'h000F0F); run_frame();
    push_pair(24'h008000, 24'h000001); run_frame();
    end_phase();
    // R6 R7: 8-bit, upper bits ignored, long half-frame
    start_phase(1'b0, 2'd0, 12);
    push_pair(24'hFFFF5A, 24'h0000C3); run_frame();
    push_pair(24'h000081, 24'hAB007E); run_frame();
    end_phase();
    // R8: 24-bit, short half-frame
    start_phase(1'b1, 2'd2, 20);
    push_pair(24'hABCDEF, 24'h123456); run_frame();
    end_phase();
    // R6: code 3 also selects 24 bits
    start_phase(1'b1, 2'd3, 24);
    push_pair(24'h800001, 24'h7FFFFE); run_frame();
    end_phase();
    // R5 R7 R10: I2S 24-bit in a 32-period half-frame
    start_phase(1'b0, 2'd2, 32);
    push_pair(24'hC0FFEE, 24'h5A5A5A); run_frame();
    push_none(); run_frame();
    end_phase();
    finish_run();
  end
endmodule